// File: doc/BRIEF.md
# Dual-Channel Serial Converter Readout Controller

This block is the host side of a three-wire serial link to a two-channel sampling converter. A frame begins when one of two things happens: a single-cycle start request arrives, or a programmable period counter expires while automatic mode is on. The controller lowers the active-low select line and waits a short setup gap. It then produces a fixed number of serial clock pulses, dividing them down from the system clock. During the frame it places the channel choice for the following conversion on its data-out line. At the same time it collects the converter's returned bits.

When the frame ends, the controller releases the select line. It then offers the decoded result, the channel tag and a consistency flag on a valid/ready output. Before the next frame can start, it keeps a quiet gap after the final falling serial clock edge. A start request that arrives while a frame or the quiet gap is running is dropped. A frame also cannot start while an earlier result is still waiting for the consumer. One parameter selects the result width: 12 bits gives 16 clocks per frame, and 10 bits gives 14.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is held and afterwards, until the first frame starts, select is high (inactive), serial clock is high, data-out is low and result valid is low.
- R2: A frame begins when a start request or an auto trigger arrives while the controller is idle and no result is waiting. Select falls, and the first falling serial clock edge follows SETUP_CYC system cycles later. Whenever select is high, serial clock is high.
- R3: A frame has exactly RES_BITS+4 falling serial clock edges. Each low phase and each high phase lasts HALF_DIV system cycles. Select rises HALF_DIV cycles after the last rising edge.
- R4: The controller changes data-out only on rising serial clock edges. Data-out carries the channel request captured when the frame started, during bit slot 1 (the value the converter samples at the 2nd falling edge). In every other slot it is 0.
- R5: The returned line is sampled at each falling edge, before the converter updates it. The bit sampled at falling edge k+1 is slot k. Slot 0 is the leading zero, slot 1 is the channel identifier and slot 2 is ignored. Slots 3 to RES_BITS+2 hold the result, MSB first.
- R6: After the last falling edge of a frame, select falls again no sooner than 2*HALF_DIV+QUIET_CYC+1 system cycles later. It stays high for at least QUIET_CYC+1 cycles.
- R7: In the cycle select rises, result valid rises. The result data carries the decoded word and the channel tag carries the slot-1 bit.
- R8: The error flag is 1 when slot 0 is 1, or when slot 1 differs from the channel requested in the frame before. Before the first frame after reset, the previous request counts as 0.
- R9: While valid is high and ready is low, valid, data, tag and flag hold steady, and no new frame starts. Valid drops in the cycle after ready is seen high.
- R10: A start request that arrives during a frame or its quiet gap is dropped, not queued.
- R11: With auto mode on, a frame starts every max(period_i, SETUP_CYC + 2*HALF_DIV*(RES_BITS+4) + QUIET_CYC + 1) system cycles.
- R12: With RES_BITS=10 the frame has 14 falling edges, and the result occupies slots 3 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-shot conversion request |
| auto_en_i | input | 1 | Enables periodic conversions |
| period_i | input | PER_W | Auto-mode frame period in system cycles |
| chan_req_i | input | 1 | Channel to select for the next conversion |
| adc_cs_n_o | output | 1 | Active-low select to the converter |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| adc_din_o | output | 1 | Serial data toward the converter |
| adc_dout_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | RES_BITS | Conversion result |
| res_chan_o | output | 1 | Channel identifier returned with the result |
| res_err_o | output | 1 | Leading-bit or channel mismatch |

## Verification
A converter model alternates the channel across consecutive frames and returns different words, including all ones, a sparse pattern and a single low bit. This separates bit-order and slot-offset faults from channel-steering faults. A corrupted leading bit and a flipped identifier are each injected on their own, so that the two error sources are told apart. Held-high start requests and auto periods above and below the frame minimum test the quiet gap against the period counter. A start pulse in mid-frame and a stalled consumer test the refusal paths. A 10-bit instance tests the shorter frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } seq_state_e;

  // Slots per frame: lead, id, ignored, result, trailing.
  function automatic int frame_len(input int res_bits);
    return res_bits + 4;
  endfunction

  function automatic int cnt_width(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1);
  endfunction

  function automatic logic frame_bad(input logic lead, input logic id,
                                     input logic expect_id);
    return lead | (id ^ expect_id);
  endfunction

endpackage

// File: rtl/adcrd_rate.sv
module adcrd_rate #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             launch_i,
  output logic             auto_due_o
);
  logic [PER_W-1:0] per_cnt;
  logic             per_sat;

  assign per_sat    = (per_cnt == '1);
  assign auto_due_o = auto_en_i && (per_cnt >= period_i);

  always_ff @(posedge clk) begin
    if (!rst_n)        per_cnt <= '1;
    else if (launch_i) per_cnt <= PER_W'(1);
    else if (!per_sat) per_cnt <= per_cnt + 1'b1;
  end

  // R11: the count restarts at each launch, so a launch never sees a stale count
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> per_cnt == PER_W'(1));

endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int FRAME     = 16,
  parameter int HALF_DIV  = 5,
  parameter int SETUP_CYC = 1,
  parameter int QUIET_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic chan_req_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic din_o,
  output logic sample_o,
  output logic publish_o,
  output logic idle_o
);
  localparam int CW = cnt_width(HALF_DIV, SETUP_CYC, QUIET_CYC);
  localparam int EW = $clog2(FRAME + 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] edges;
  logic          chan_q;
  logic          cnt_zero;
  logic          last_edge;
  logic [CW-1:0] since_cs;
  logic [CW-1:0] quiet_cnt;

  assign cnt_zero  = (cnt == '0);
  assign last_edge = (edges == EW'(FRAME));
  assign sample_o  = cnt_zero && ((st == ST_SETUP) || (st == ST_HIGH && !last_edge));
  assign publish_o = cnt_zero && (st == ST_HIGH) && last_edge;
  assign idle_o    = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      edges  <= '0;
      chan_q <= 1'b0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b1;
      din_o  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (launch_i) begin
          st     <= ST_SETUP;
          cs_n_o <= 1'b0;
          cnt    <= CW'(SETUP_CYC - 1);
          edges  <= '0;
          chan_q <= chan_req_i;
          din_o  <= 1'b0;
        end
        ST_SETUP: if (cnt_zero) begin
          st     <= ST_LOW;
          sclk_o <= 1'b0;
          edges  <= edges + 1'b1;
          cnt    <= CW'(HALF_DIV - 1);
        end else cnt <= cnt - 1'b1;
        ST_LOW: if (cnt_zero) begin
          st     <= ST_HIGH;
          sclk_o <= 1'b1;
          cnt    <= CW'(HALF_DIV - 1);
          din_o  <= (edges == EW'(1)) ? chan_q : 1'b0;
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (cnt_zero) begin
          if (last_edge) begin
            st     <= ST_GAP;
            cs_n_o <= 1'b1;
            cnt    <= CW'(QUIET_CYC - 1);
          end else begin
            st     <= ST_LOW;
            sclk_o <= 1'b0;
            edges  <= edges + 1'b1;
            cnt    <= CW'(HALF_DIV - 1);
          end
        end else cnt <= cnt - 1'b1;
        ST_GAP: if (cnt_zero) st <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Observation counters for the timing properties below.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_cs  <= '0;
      quiet_cnt <= '1;
    end else begin
      since_cs  <= cs_n_o ? '0 : ((since_cs == '1) ? since_cs : since_cs + 1'b1);
      quiet_cnt <= sample_o ? '0 : ((quiet_cnt == '1) ? quiet_cnt : quiet_cnt + 1'b1);
    end
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  p_setup_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && edges == EW'(1)) |-> since_cs >= CW'(SETUP_CYC));

  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> edges == EW'(FRAME));

  p_din_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    din_o |-> (!cs_n_o && (edges == EW'(1) || edges == EW'(2))));

  p_quiet_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> quiet_cnt >= CW'(QUIET_CYC));

endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture
  import adcrd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_i,
  input  logic                chan_req_i,
  input  logic                sample_i,
  input  logic                dout_i,
  input  logic                publish_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                chan_o,
  output logic                err_o
);
  localparam int FRAME = frame_len(RES_BITS);
  localparam int ID_AT = RES_BITS + 2;
  localparam int LD_AT = RES_BITS + 3;

  logic [FRAME-1:0] shreg;
  logic             cur_req;
  logic             prev_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cur_req  <= 1'b0;
      prev_req <= 1'b0;
      valid_o  <= 1'b0;
      data_o   <= '0;
      chan_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      if (sample_i) shreg <= {shreg[FRAME-2:0], dout_i};
      if (launch_i) begin
        prev_req <= cur_req;
        cur_req  <= chan_req_i;
      end
      if (publish_i) begin
        valid_o <= 1'b1;
        data_o  <= shreg[RES_BITS:1];
        chan_o  <= shreg[ID_AT];
        err_o   <= frame_bad(shreg[LD_AT], shreg[ID_AT], prev_req);
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    publish_i |-> !valid_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(chan_o) && $stable(err_o)));

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !publish_i) |=> !valid_o);

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import adcrd_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int HALF_DIV  = 5,
  parameter int SETUP_CYC = 1,
  parameter int QUIET_CYC = 2,
  parameter int PER_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                auto_en_i,
  input  logic [PER_W-1:0]    period_i,
  input  logic                chan_req_i,
  output logic                adc_cs_n_o,
  output logic                adc_sclk_o,
  output logic                adc_din_o,
  input  logic                adc_dout_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [RES_BITS-1:0] res_data_o,
  output logic                res_chan_o,
  output logic                res_err_o
);
  localparam int FRAME = frame_len(RES_BITS);

  logic seq_idle;
  logic auto_due;
  logic slot_free;
  logic launch;
  logic sample_stb;
  logic publish;

  assign slot_free = !res_valid_o || res_ready_i;
  assign launch    = seq_idle && slot_free && (start_i || auto_due);

  adcrd_rate #(.PER_W(PER_W)) rate_i (
    .clk(clk), .rst_n(rst_n), .auto_en_i(auto_en_i), .period_i(period_i),
    .launch_i(launch), .auto_due_o(auto_due)
  );

  adcrd_seq #(
    .FRAME(FRAME), .HALF_DIV(HALF_DIV), .SETUP_CYC(SETUP_CYC), .QUIET_CYC(QUIET_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .chan_req_i(chan_req_i),
    .cs_n_o(adc_cs_n_o), .sclk_o(adc_sclk_o), .din_o(adc_din_o),
    .sample_o(sample_stb), .publish_o(publish), .idle_o(seq_idle)
  );

  adcrd_capture #(.RES_BITS(RES_BITS)) cap_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .chan_req_i(chan_req_i),
    .sample_i(sample_stb), .dout_i(adc_dout_i), .publish_i(publish),
    .ready_i(res_ready_i), .valid_o(res_valid_o), .data_o(res_data_o),
    .chan_o(res_chan_o), .err_o(res_err_o)
  );

  // R10: start while busy never opens a frame
  p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !seq_idle) |=> !$fell(adc_cs_n_o));

endmodule

// File: tb/dual_adc_reader_tb_top.sv
module adc_model #(
  parameter int RES = 12
) (
  input  logic        clk,
  input  int          cyc,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        din,
  output logic        dout
);
  localparam int F = RES + 4;
  logic [RES-1:0] val0, val1;
  logic flip_lead, flip_chan;
  logic cs_p = 1'b1, sclk_p = 1'b1, cur_chan = 1'b0, nxt_chan = 1'b0;
  int idx = 0, falls = 0, din_extra = 0, frames = 0;
  int cs_fall_c = 0, prev_cs_fall_c = 0, first_fall_c = 0, last_fall_c = 0;
  int cs_rise_c = 0, gap_c = 0;
  logic [F-1:0] word;

  assign word = {flip_lead, cur_chan ^ flip_chan, 1'b0, (cur_chan ? val1 : val0), 1'b0};
  assign dout = (!cs_n && idx < F) ? word[F-1-idx] : 1'b0;

  always @(posedge clk) begin
    cs_p   <= cs_n;
    sclk_p <= sclk;
    if (!cs_n && cs_p) begin
      falls          <= 0;
      din_extra      <= 0;
      prev_cs_fall_c <= cs_fall_c;
      cs_fall_c      <= cyc;
      gap_c          <= cyc - last_fall_c;
      frames         <= frames + 1;
    end else if (!cs_n && sclk_p && !sclk) begin
      falls       <= falls + 1;
      idx         <= idx + 1;
      last_fall_c <= cyc;
      if (falls == 0) first_fall_c <= cyc;
      if (falls == 1) nxt_chan <= din;
      else if (din) din_extra <= din_extra + 1;
    end
    if (cs_n && !cs_p) begin
      cs_rise_c <= cyc;
      cur_chan  <= nxt_chan;
      idx       <= 0;
    end
  end
endmodule

module dual_adc_reader_tb_top;
  localparam int H = 5, S = 1, Q = 2;
  localparam int MINP = S + 2 * H * 16 + Q + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic        start = 0, auto_en = 0, chan_req = 0, ready = 1;
  logic [15:0] period = 16'd0;
  logic        cs_n, sclk, din, dout, valid, chan, err;
  logic [11:0] data;

  dual_adc_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en), .period_i(period),
    .chan_req_i(chan_req), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .adc_din_o(din),
    .adc_dout_i(dout), .res_valid_o(valid), .res_ready_i(ready), .res_data_o(data),
    .res_chan_o(chan), .res_err_o(err)
  );
  adc_model #(.RES(12)) adc12_i (.clk(clk), .cyc(cyc), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout));

  logic       start10 = 0;
  logic       cs10, sclk10, din10, dout10, valid10, chan10, err10;
  logic [9:0] data10;

  dual_adc_reader #(.RES_BITS(10)) dut10_i (
    .clk(clk), .rst_n(rst_n), .start_i(start10), .auto_en_i(1'b0), .period_i(16'd0),
    .chan_req_i(1'b0), .adc_cs_n_o(cs10), .adc_sclk_o(sclk10), .adc_din_o(din10),
    .adc_dout_i(dout10), .res_valid_o(valid10), .res_ready_i(1'b1), .res_data_o(data10),
    .res_chan_o(chan10), .res_err_o(err10)
  );
  adc_model #(.RES(10)) adc10_i (.clk(clk), .cyc(cyc), .cs_n(cs10), .sclk(sclk10), .din(din10), .dout(dout10));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 3000 && !valid; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 idle lines", {cs_n, sclk}, 2'b11);
    chk(din == 1'b0 && valid == 1'b0, "R1 din/valid", {din, valid}, 2'b00);
  endtask

  task automatic t_frame(input logic req, input logic [11:0] exp_d,
                         input logic exp_c, input logic exp_e);
    chan_req = req;
    pulse_start();
    wait_valid();
    chk(valid == 1'b1, "R7 valid", valid, 1);
    chk(data == exp_d, "R5 R7 data", data, exp_d);
    chk(chan == exp_c, "R7 tag", chan, exp_c);
    chk(err == exp_e, "R8 flag", err, exp_e);
    repeat (8) @(negedge clk);
    chk(adc12_i.falls == 16, "R3 edges", adc12_i.falls, 16);
    chk(adc12_i.first_fall_c - adc12_i.cs_fall_c == S, "R2 setup lead",
        adc12_i.first_fall_c - adc12_i.cs_fall_c, S);
    chk(adc12_i.last_fall_c - adc12_i.first_fall_c == 15 * 2 * H, "R3 phases",
        adc12_i.last_fall_c - adc12_i.first_fall_c, 15 * 2 * H);
    chk(adc12_i.cs_rise_c - adc12_i.last_fall_c == 2 * H, "R3 select rise",
        adc12_i.cs_rise_c - adc12_i.last_fall_c, 2 * H);
    chk(adc12_i.nxt_chan == req && adc12_i.din_extra == 0, "R4 din slot",
        {adc12_i.nxt_chan, 1'b0}, {req, 1'b0});
  endtask

  task automatic t_quiet();
    int f0;
    f0 = adc12_i.frames;
    start = 1'b1;
    for (int i = 0; i < 2000 && adc12_i.frames < f0 + 2; i++) @(negedge clk);
    start = 1'b0;
    chk(adc12_i.gap_c == 2 * H + Q + 1, "R6 quiet gap", adc12_i.gap_c, 2 * H + Q + 1);
    chk(adc12_i.cs_fall_c - adc12_i.cs_rise_c == Q + 1, "R6 select high",
        adc12_i.cs_fall_c - adc12_i.cs_rise_c, Q + 1);
    wait_valid();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_refuse();
    int f0;
    f0 = adc12_i.frames;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_valid();
    repeat (100) @(negedge clk);
    chk(adc12_i.frames == f0 + 1, "R10 refused start", adc12_i.frames, f0 + 1);
  endtask

  task automatic t_backpressure();
    int f0;
    logic [11:0] d0;
    ready = 1'b0;
    f0 = adc12_i.frames;
    pulse_start();
    wait_valid();
    d0 = data;
    pulse_start();
    repeat (300) @(negedge clk);
    chk(adc12_i.frames == f0 + 1, "R9 no frame while held", adc12_i.frames, f0 + 1);
    chk(valid == 1'b1 && data == d0, "R9 hold", data, d0);
    ready = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R9 accept", valid, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_auto(input int per, input int exp_int);
    int f0;
    period = 16'(per);
    auto_en = 1'b1;
    f0 = adc12_i.frames;
    for (int i = 0; i < 3000 && adc12_i.frames < f0 + 3; i++) @(negedge clk);
    chk(adc12_i.cs_fall_c - adc12_i.prev_cs_fall_c == exp_int, "R11 period",
        adc12_i.cs_fall_c - adc12_i.prev_cs_fall_c, exp_int);
    auto_en = 1'b0;
    repeat (200) @(negedge clk);
  endtask

  task automatic t_narrow();
    start10 = 1'b1;
    @(negedge clk);
    start10 = 1'b0;
    for (int i = 0; i < 3000 && !valid10; i++) @(negedge clk);
    chk(data10 == 10'h2B7 && chan10 == 1'b0 && err10 == 1'b0, "R12 result",
        {err10, chan10, data10}, 12'h2B7);
    repeat (8) @(negedge clk);
    chk(adc10_i.falls == 14, "R12 edges", adc10_i.falls, 14);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    adc12_i.val0 = 12'hA5C; adc12_i.val1 = 12'h3C1;
    adc12_i.flip_lead = 1'b0; adc12_i.flip_chan = 1'b0;
    adc10_i.val0 = 10'h2B7; adc10_i.val1 = 10'h155;
    adc10_i.flip_lead = 1'b0; adc10_i.flip_chan = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_frame(1'b1, 12'hA5C, 1'b0, 1'b0);
    t_frame(1'b0, 12'h3C1, 1'b1, 1'b0);
    adc12_i.val0 = 12'hFFF;
    t_frame(1'b1, 12'hFFF, 1'b0, 1'b0);
    adc12_i.val1 = 12'h001;
    adc12_i.flip_lead = 1'b1;
    t_frame(1'b1, 12'h001, 1'b1, 1'b1);
    adc12_i.flip_lead = 1'b0;
    adc12_i.flip_chan = 1'b1;
    t_frame(1'b0, 12'h001, 1'b0, 1'b1);
    adc12_i.flip_chan = 1'b0;
    t_quiet();
    t_refuse();
    t_backpressure();
    t_auto(300, 300);
    t_auto(40, MINP);
    t_narrow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule